// File: doc/BRIEF.md
# Operand-Compare Condition Evaluator

This block decides whether a conditionally executed instruction is allowed to run. It holds no flag bits. It keeps the two operands of the most recent flag-setting operation and a small tag that records which kind of comparison produced them. Three kinds are defined: an arithmetic compare (subtraction), a bitwise test (AND) and an equivalence test (XOR). When an instruction word is presented for evaluation, the block takes its 4-bit condition field and computes the verdict directly from the saved operands and the tag.

A flag-setting instruction writes the operand store through a write strobe. A conditional instruction asks for a verdict through an evaluate strobe. One clock later, the block returns a registered execute-enable, and it also returns an error strobe when the condition has no meaning for the stored compare kind. An error always suppresses execution.

Top module: `cmp_cond_eval`

## Requirements
- R1: After synchronous reset the outputs `res_valid`, `exec_en` and `cond_err` are 0. The stored operands are both zero and the tag is the subtract kind, so an EQ (0) evaluation with no prior write executes.
- R2: The condition is instruction bits 31:28. No other instruction bit affects the verdict.
- R3: Subtract kind (tag 0): code 0 executes when the operands are equal and code 1 executes when they differ.
- R4: Subtract kind: codes 2, 3, 8 and 9 execute when operand A is unsigned greater-or-equal, less, greater and less-or-equal with respect to operand B.
- R5: Subtract kind: codes 10, 11, 12 and 13 are the same four relations with both operands taken as signed two's complement.
- R6: Subtract kind: code 4 executes when bit 31 of (A - B) mod 2^32 is 1, and code 5 executes when that bit is 0.
- R7: For every tag, code 14 executes and code 15 never executes. Neither raises the error.
- R8: Equivalence kind (tag 2): with R = A ^ B, code 0 executes when R == 0, code 1 when R != 0, code 4 when R[31] = 1 and code 5 when R[31] = 0.
- R9: Bitwise-test kind (tag 1): the same four codes as in R8, evaluated on R = A & B.
- R10: `cond_err` is raised, and `exec_en` is held at 0, in these cases: codes 6 and 7 under any tag; codes 2, 3 and 8 to 13 under tags 1 and 2; and every code except 14 and 15 under the unused tag 3.
- R11: The operands and the tag change only in a cycle where `upd_valid` is 1. An evaluation in the same cycle as a write uses the values stored before that write.
- R12: The outputs are registered. `res_valid` is 1 exactly in the cycle after an `eval_valid` cycle. In any other cycle, `exec_en` and `cond_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | Write strobe from a flag-setting instruction |
| upd_kind | input | 2 | Compare kind: 0 subtract, 1 AND test, 2 XOR test, 3 unused |
| upd_a | input | 32 | First operand of the compare |
| upd_b | input | 32 | Second operand of the compare |
| eval_valid | input | 1 | Request a verdict for `instr` |
| instr | input | 32 | Instruction word; condition in bits 31:28 |
| res_valid | output | 1 | Verdict valid (one cycle after `eval_valid`) |
| exec_en | output | 1 | Instruction should execute |
| cond_err | output | 1 | Condition cannot be evaluated for the stored kind |

## Verification
The hardest cases to reach are those where the signed relation and the sign of the wrapped difference disagree, because they only appear when the subtraction overflows. The stimulus sets this up by storing the most negative value against a positive one, so that LT executes while MI does not. A second hard case is a write and an evaluation that land in the same cycle. The bench drives both strobes on the same edge and then evaluates again on the following edge, which shows the old operands and then the new ones.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;

  typedef enum logic [1:0] {
    KIND_SUB  = 2'd0,
    KIND_AND  = 2'd1,
    KIND_XOR  = 2'd2,
    KIND_RSVD = 2'd3
  } cmp_kind_e;

  typedef enum logic [3:0] {
    CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_HS = 4'd2,  CC_LO = 4'd3,
    CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
    CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
    CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
  } cond_e;

  typedef struct packed {
    logic go;
    logic err;
  } verdict_t;

endpackage

// File: rtl/cce_operand_store.sv
module cce_operand_store
  import cond_eval_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  cmp_kind_e     wr_kind,
  input  logic [DW-1:0] wr_a,
  input  logic [DW-1:0] wr_b,
  output cmp_kind_e     kind_q,
  output logic [DW-1:0] a_q,
  output logic [DW-1:0] b_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= KIND_SUB;
      a_q    <= '0;
      b_q    <= '0;
    end else if (wr_en) begin
      kind_q <= wr_kind;
      a_q    <= wr_a;
      b_q    <= wr_b;
    end
  end

  // R11: contents move only on a write strobe
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> ($stable(a_q) && $stable(b_q) && $stable(kind_q)));

endmodule

// File: rtl/cce_cond_decode.sv
module cce_cond_decode
  import cond_eval_pkg::*;
#(
  parameter int DW = 32
) (
  input  cmp_kind_e     kind,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [3:0]    cond,
  output verdict_t      verdict
);

  localparam int SB = DW - 1;

  logic          same;
  logic          u_less;
  logic          s_less;
  logic [DW-1:0] diff;
  logic [DW-1:0] bits;
  logic          bits_zero;

  always_comb begin
    same      = (a == b);
    u_less    = (a < b);
    s_less    = ($signed(a) < $signed(b));
    diff      = a - b;
    bits      = (kind == KIND_AND) ? (a & b) : (a ^ b);
    bits_zero = (bits == '0);
  end

  always_comb begin
    verdict.go  = 1'b0;
    verdict.err = 1'b0;
    if (cond == CC_AL) begin
      verdict.go = 1'b1;
    end else if (cond == CC_NV) begin
      verdict.go = 1'b0;
    end else begin
      unique case (kind)
        KIND_SUB: begin
          unique case (cond)
            CC_EQ:   verdict.go = same;
            CC_NE:   verdict.go = !same;
            CC_HS:   verdict.go = !u_less;
            CC_LO:   verdict.go = u_less;
            CC_MI:   verdict.go = diff[SB];
            CC_PL:   verdict.go = !diff[SB];
            CC_HI:   verdict.go = !u_less && !same;
            CC_LS:   verdict.go = u_less || same;
            CC_GE:   verdict.go = !s_less;
            CC_LT:   verdict.go = s_less;
            CC_GT:   verdict.go = !s_less && !same;
            CC_LE:   verdict.go = s_less || same;
            default: verdict.err = 1'b1;
          endcase
        end
        KIND_AND, KIND_XOR: begin
          unique case (cond)
            CC_EQ:   verdict.go = bits_zero;
            CC_NE:   verdict.go = !bits_zero;
            CC_MI:   verdict.go = bits[SB];
            CC_PL:   verdict.go = !bits[SB];
            default: verdict.err = 1'b1;
          endcase
        end
        default: verdict.err = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/cce_result_reg.sv
module cce_result_reg
  import cond_eval_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     req,
  input  verdict_t verdict,
  output logic     vld_q,
  output logic     exec_q,
  output logic     err_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      exec_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      vld_q  <= req;
      exec_q <= req && verdict.go && !verdict.err;
      err_q  <= req && verdict.err;
    end
  end

  // R10: an error never comes with an execute
  p_err_blocks_exec_r10: assert property (@(posedge clk) disable iff (rst)
    err_q |-> !exec_q);

  // R12: quiet outputs outside a response cycle
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !vld_q |-> (!exec_q && !err_q));

  // R12: a request is answered on the next edge
  p_answer_r12: assert property (@(posedge clk) disable iff (rst)
    req |=> vld_q);

endmodule

// File: rtl/cmp_cond_eval.sv
module cmp_cond_eval
  import cond_eval_pkg::*;
#(
  parameter int DW = 32,
  parameter int IW = 32,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_valid,
  input  logic [1:0]    upd_kind,
  input  logic [DW-1:0] upd_a,
  input  logic [DW-1:0] upd_b,
  input  logic          eval_valid,
  input  logic [IW-1:0] instr,
  output logic          res_valid,
  output logic          exec_en,
  output logic          cond_err
);

  localparam int CLO = IW - CW;

  cmp_kind_e     st_kind;
  logic [DW-1:0] st_a;
  logic [DW-1:0] st_b;
  logic [CW-1:0] cond_f;
  verdict_t      vd;
  logic          unused_body;

  assign cond_f      = instr[IW-1:CLO];
  assign unused_body = ^instr[CLO-1:0];

  cce_operand_store #(.DW(DW)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (upd_valid),
    .wr_kind (cmp_kind_e'(upd_kind)),
    .wr_a    (upd_a),
    .wr_b    (upd_b),
    .kind_q  (st_kind),
    .a_q     (st_a),
    .b_q     (st_b)
  );

  cce_cond_decode #(.DW(DW)) u_dec (
    .kind    (st_kind),
    .a       (st_a),
    .b       (st_b),
    .cond    (cond_f),
    .verdict (vd)
  );

  cce_result_reg u_out (
    .clk     (clk),
    .rst     (rst),
    .req     (eval_valid),
    .verdict (vd),
    .vld_q   (res_valid),
    .exec_q  (exec_en),
    .err_q   (cond_err)
  );

  // R7: always-code executes without error
  p_always_r7: assert property (@(posedge clk) disable iff (rst)
    (eval_valid && instr[IW-1:CLO] == 4'hE) |=> (exec_en && !cond_err));

  // R7: never-code does not execute and raises no error
  p_never_r7: assert property (@(posedge clk) disable iff (rst)
    (eval_valid && instr[IW-1:CLO] == 4'hF) |=> (!exec_en && !cond_err));

  // R10: overflow codes are flagged for every kind
  p_ovf_err_r10: assert property (@(posedge clk) disable iff (rst)
    (eval_valid && instr[IW-1:CLO+1] == 3'b011) |=> cond_err);

endmodule

// File: tb/sim_cmp_cond_eval.sv
`timescale 1ns/1ps
module sim_cmp_cond_eval;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd_valid = 1'b0;
  logic [1:0]  upd_kind = 2'd0;
  logic [31:0] upd_a = '0;
  logic [31:0] upd_b = '0;
  logic        eval_valid = 1'b0;
  logic [31:0] instr = '0;
  logic        res_valid;
  logic        exec_en;
  logic        cond_err;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cmp_cond_eval u0 (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_kind(upd_kind),
    .upd_a(upd_a), .upd_b(upd_b), .eval_valid(eval_valid), .instr(instr),
    .res_valid(res_valid), .exec_en(exec_en), .cond_err(cond_err)
  );

  // {kind, a, b, cond, exec, err, req}
  localparam int NV = 44;
  localparam logic [75:0] VEC [0:NV-1] = '{
    {2'd0, 32'h5, 32'h5, 4'd0, 1'b1, 1'b0, 4'd3},            // R3
    {2'd0, 32'h5, 32'h5, 4'd1, 1'b0, 1'b0, 4'd3},            // R3
    {2'd0, 32'h5, 32'h6, 4'd1, 1'b1, 1'b0, 4'd3},            // R3
    {2'd0, 32'h1, 32'hFFFFFFFF, 4'd2, 1'b0, 1'b0, 4'd4},     // R4
    {2'd0, 32'h1, 32'hFFFFFFFF, 4'd3, 1'b1, 1'b0, 4'd4},
    {2'd0, 32'h1, 32'hFFFFFFFF, 4'd8, 1'b0, 1'b0, 4'd4},
    {2'd0, 32'h1, 32'hFFFFFFFF, 4'd9, 1'b1, 1'b0, 4'd4},
    {2'd0, 32'h7, 32'h7, 4'd2, 1'b1, 1'b0, 4'd4},
    {2'd0, 32'h7, 32'h7, 4'd8, 1'b0, 1'b0, 4'd4},
    {2'd0, 32'h7, 32'h7, 4'd9, 1'b1, 1'b0, 4'd4},
    {2'd0, 32'h1, 32'hFFFFFFFF, 4'd10, 1'b1, 1'b0, 4'd5},    // R5
    {2'd0, 32'h1, 32'hFFFFFFFF, 4'd11, 1'b0, 1'b0, 4'd5},
    {2'd0, 32'h1, 32'hFFFFFFFF, 4'd12, 1'b1, 1'b0, 4'd5},
    {2'd0, 32'h1, 32'hFFFFFFFF, 4'd13, 1'b0, 1'b0, 4'd5},
    {2'd0, 32'h7, 32'h7, 4'd10, 1'b1, 1'b0, 4'd5},
    {2'd0, 32'h7, 32'h7, 4'd12, 1'b0, 1'b0, 4'd5},
    {2'd0, 32'h7, 32'h7, 4'd13, 1'b1, 1'b0, 4'd5},
    {2'd0, 32'h80000000, 32'h1, 4'd11, 1'b1, 1'b0, 4'd5},
    {2'd0, 32'h80000000, 32'h1, 4'd4, 1'b0, 1'b0, 4'd6},     // R6
    {2'd0, 32'h80000000, 32'h1, 4'd5, 1'b1, 1'b0, 4'd6},
    {2'd0, 32'h3, 32'h5, 4'd4, 1'b1, 1'b0, 4'd6},
    {2'd0, 32'h3, 32'h5, 4'd5, 1'b0, 1'b0, 4'd6},
    {2'd0, 32'h3, 32'h5, 4'd6, 1'b0, 1'b1, 4'd10},           // R10
    {2'd0, 32'h3, 32'h5, 4'd7, 1'b0, 1'b1, 4'd10},
    {2'd0, 32'h3, 32'h5, 4'd14, 1'b1, 1'b0, 4'd7},           // R7
    {2'd0, 32'h5, 32'h5, 4'd15, 1'b0, 1'b0, 4'd7},
    {2'd2, 32'hF0, 32'hF0, 4'd0, 1'b1, 1'b0, 4'd8},          // R8
    {2'd2, 32'hF0, 32'hF0, 4'd1, 1'b0, 1'b0, 4'd8},
    {2'd2, 32'h80000000, 32'h0, 4'd4, 1'b1, 1'b0, 4'd8},
    {2'd2, 32'h80000000, 32'h0, 4'd5, 1'b0, 1'b0, 4'd8},
    {2'd2, 32'h80000000, 32'h80000000, 4'd5, 1'b1, 1'b0, 4'd8},
    {2'd2, 32'h1, 32'h2, 4'd3, 1'b0, 1'b1, 4'd10},
    {2'd2, 32'h1, 32'h2, 4'd12, 1'b0, 1'b1, 4'd10},
    {2'd2, 32'h1, 32'h2, 4'd7, 1'b0, 1'b1, 4'd10},
    {2'd1, 32'hF0, 32'h0F, 4'd0, 1'b1, 1'b0, 4'd9},          // R9
    {2'd1, 32'hF0, 32'h0F, 4'd1, 1'b0, 1'b0, 4'd9},
    {2'd1, 32'h80000001, 32'h80000000, 4'd4, 1'b1, 1'b0, 4'd9},
    {2'd1, 32'h80000001, 32'h80000000, 4'd1, 1'b1, 1'b0, 4'd9},
    {2'd1, 32'h80000001, 32'h7FFFFFFF, 4'd5, 1'b1, 1'b0, 4'd9},
    {2'd1, 32'h1, 32'h1, 4'd10, 1'b0, 1'b1, 4'd10},
    {2'd1, 32'h1, 32'h1, 4'd14, 1'b1, 1'b0, 4'd7},
    {2'd1, 32'h1, 32'h1, 4'd15, 1'b0, 1'b0, 4'd7},
    {2'd3, 32'h4, 32'h4, 4'd0, 1'b0, 1'b1, 4'd10},
    {2'd3, 32'h4, 32'h4, 4'd14, 1'b1, 1'b0, 4'd7}
  };

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {valid,exec,err} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic write_ops(input logic [1:0] k, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    upd_valid = 1'b1; upd_kind = k; upd_a = a; upd_b = b;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic eval_now(input logic [31:0] word);
    eval_valid = 1'b1; instr = word;
    @(negedge clk);
    eval_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset outputs
    check("R1 outputs", {res_valid, exec_en, cond_err}, 3'b000);
    // R1: zero operands, subtract kind -> EQ executes, HI does not
    eval_now(32'h0000_0000);
    check("R1 EQ after reset", {res_valid, exec_en, cond_err}, 3'b110);
    eval_now(32'h8000_0000);
    check("R1 HI after reset", {res_valid, exec_en, cond_err}, 3'b100);

    for (int i = 0; i < NV; i++) begin
      write_ops(VEC[i][75:74], VEC[i][73:42], VEC[i][41:10]);
      eval_now({VEC[i][9:6], 28'h0});
      checks++;
      if ({res_valid, exec_en, cond_err} !== {1'b1, VEC[i][5:4]}) begin
        errors++;
        $display("FAIL R%0d vector %0d: actual %b expected %b", VEC[i][3:0], i,
                 {res_valid, exec_en, cond_err}, {1'b1, VEC[i][5:4]});
      end
    end

    // R2: body bits do not matter
    write_ops(2'd0, 32'h9, 32'h9);
    eval_now(32'h0FFF_FFFF);
    check("R2 EQ with body ones", {res_valid, exec_en, cond_err}, 3'b110);
    eval_now(32'h1ABC_DEF0);
    check("R2 NE with body pattern", {res_valid, exec_en, cond_err}, 3'b100);

    // R12: idle cycle is quiet
    @(negedge clk);
    check("R12 idle", {res_valid, exec_en, cond_err}, 3'b000);

    // R11: write and evaluate on the same edge use the old operands
    @(negedge clk);
    upd_valid = 1'b1; upd_kind = 2'd0; upd_a = 32'h1; upd_b = 32'h2;
    eval_valid = 1'b1; instr = 32'h0000_0000;
    @(negedge clk);
    upd_valid = 1'b0; eval_valid = 1'b0;
    check("R11 same-cycle old operands", {res_valid, exec_en, cond_err}, 3'b110);
    eval_now(32'h0000_0000);
    check("R11 new operands visible", {res_valid, exec_en, cond_err}, 3'b100);
    // R11: evaluations without writes leave operands unchanged
    eval_now(32'h3000_0000);
    check("R11 LO still holds", {res_valid, exec_en, cond_err}, 3'b110);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule